// File: doc/BRIEF.md
# Control Endpoint Direction-Switched FIFO

This block is the byte buffer behind a USB device's control endpoint. A single 16-entry storage array is shared by both directions of traffic. The direction is not chosen by software. A small protocol state machine decides it. After reset the machine waits in an idle state. When the packet side reports the start of a setup command, the buffer is flushed and the packet side pushes the command bytes. The processor drains those bytes by reading a 32-bit data register.

When the packet side marks the command complete, it also says whether the command calls for a data reply. Only in that case does the machine open the buffer to processor writes. The processor then loads the response and raises a strobe. That strobe hands the buffer to the packet side, which pops the bytes for transmission. When the last byte has left, the machine falls back to idle. A new setup command in any state flushes everything and restarts the receive phase. Fill level, empty, full and two sticky error flags are exposed.

Top module: `ctl_ep_fifo`

## Requirements
- R1: After a synchronous active-high reset, ep_state is 0 (idle), fill_count is 0, fifo_empty is 1, fifo_full is 0, and overflow and underflow are both 0.
- R2: A cycle with setup_start high, in any state, empties the buffer, clears both sticky flags and moves ep_state to 1 (command receive). It takes priority over every other input in that cycle.
- R3: usb_push appends usb_wdata to the buffer only while ep_state is 1. In every other state it leaves fill_count unchanged.
- R4: A processor read (reg_rd) in ep_state 0, 1 or 2 returns the oldest byte in reg_rdata[7:0] during that cycle and removes that byte at the clock edge. reg_rdata[31:8] always reads zero.
- R5: A processor read while the buffer is empty returns zero and sets underflow. Underflow stays set until reset or setup_start.
- R6: setup_done in ep_state 1 moves the state to 2 (reply load) if setup_needs_reply is high, and to 0 (idle) if it is low.
- R7: A processor write (reg_wr) adds reg_wdata to the newest end of the buffer only in ep_state 2. In states 0, 1 and 3 the write is ignored and fill_count does not change because of it.
- R8: A push, from either side, while fill_count is 16 is dropped and sets overflow. Overflow stays set until reset or setup_start. Fullness is judged on the count at the start of the cycle, even if a read happens in the same cycle.
- R9: resp_loaded in ep_state 2 moves the state to 3 (transmit). In state 3, usb_rdata shows the oldest byte and usb_pop removes it, so the bytes leave in the order the processor wrote them. usb_rdata is zero whenever the state is not 3 or the buffer is empty.
- R10: In ep_state 3 the state returns to 0 on the edge where the last byte is popped. If the state is 3 with an empty buffer, it returns to 0 on the next edge.
- R11: fill_count always equals the number of stored bytes, never exceeds 16, fifo_empty is high exactly when it is 0 and fifo_full exactly when it is 16.
- R12: A processor read in ep_state 3 returns zero and neither removes a byte nor sets underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Processor read of the data register (pops one byte) |
| reg_wr | input | 1 | Processor write of the data register |
| reg_wdata | input | 8 | Byte written by the processor |
| reg_rdata | output | 32 | Data register read value, bits 31:8 zero |
| resp_loaded | input | 1 | Processor strobe: response is loaded, hand the buffer to transmit |
| setup_start | input | 1 | Packet side: new setup command begins (flush and restart) |
| setup_done | input | 1 | Packet side: setup command bytes complete |
| setup_needs_reply | input | 1 | Qualifies setup_done: the command needs a data reply |
| usb_push | input | 1 | Packet side push of a received command byte |
| usb_wdata | input | 8 | Byte pushed by the packet side |
| usb_pop | input | 1 | Packet side pop of a byte for transmission |
| usb_rdata | output | 8 | Oldest byte, shown while transmitting |
| ep_state | output | 2 | 0 idle, 1 command receive, 2 reply load, 3 transmit |
| fill_count | output | 5 | Number of stored bytes |
| fifo_empty | output | 1 | Buffer holds no byte |
| fifo_full | output | 1 | Buffer holds 16 bytes |
| overflow | output | 1 | Sticky: a push was dropped because the buffer was full |
| underflow | output | 1 | Sticky: a processor read found the buffer empty |

## Verification
The bench targets the cycles where direction rules collide. These include a processor write while idle or transmitting, which a design granting writes too freely would let into the buffer. They include a read and a write in the same cycle on a full buffer, where a design that judged fullness after the read would accept the write and miss the overflow flag. They also include a read and a write on an empty buffer, where the read must underflow while the write still lands. A setup command arriving in the middle of transmit must flush stale bytes; a design that only reset the state would replay old response data. A reply of zero bytes must drop back to idle, where a design waiting for a final pop would hang in transmit. Pointer wrap past 16 entries is covered by long random runs against a queue model, which would expose any mis-sized pointer as reordered bytes.

// File: rtl/ctl_ep_fifo.sv
module ctl_ep_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int RW    = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_rd,
  input  logic                         reg_wr,
  input  logic [DW-1:0]                reg_wdata,
  output logic [RW-1:0]                reg_rdata,
  input  logic                         resp_loaded,
  input  logic                         setup_start,
  input  logic                         setup_done,
  input  logic                         setup_needs_reply,
  input  logic                         usb_push,
  input  logic [DW-1:0]                usb_wdata,
  input  logic                         usb_pop,
  output logic [DW-1:0]                usb_rdata,
  output logic [1:0]                   ep_state,
  output logic [$clog2(DEPTH+1)-1:0]   fill_count,
  output logic                         fifo_empty,
  output logic                         fifo_full,
  output logic                         overflow,
  output logic                         underflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RX = 2'd1, ST_REPLY = 2'd2, ST_TX = 2'd3} st_t;

  st_t            st;
  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic           ovf, unf;

  logic           cpu_rd_win, cpu_pop, usb_pop_ok;
  logic           cpu_wr_try, usb_push_try, push_ok, pop_ok;
  logic [DW-1:0]  head, push_byte;

  assign fifo_empty = (cnt == '0);
  assign fifo_full  = (cnt == CW'(DEPTH));
  assign head       = mem[rp];

  assign cpu_rd_win   = reg_rd && (st != ST_TX);
  assign cpu_pop      = cpu_rd_win && !fifo_empty;
  assign usb_pop_ok   = usb_pop && (st == ST_TX) && !fifo_empty;
  assign pop_ok       = cpu_pop || usb_pop_ok;
  assign cpu_wr_try   = reg_wr && (st == ST_REPLY);
  assign usb_push_try = usb_push && (st == ST_RX);
  assign push_ok      = (cpu_wr_try || usb_push_try) && !fifo_full;
  assign push_byte    = (st == ST_REPLY) ? reg_wdata : usb_wdata;

  assign reg_rdata  = cpu_pop ? RW'(head) : '0;
  assign usb_rdata  = ((st == ST_TX) && !fifo_empty) ? head : '0;
  assign ep_state   = st;
  assign fill_count = cnt;
  assign overflow   = ovf;
  assign underflow  = unf;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !setup_start) mem[wp] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (setup_start) begin
      st  <= ST_RX;
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      if ((cpu_wr_try || usb_push_try) && fifo_full) ovf <= 1'b1;
      if (cpu_rd_win && fifo_empty) unf <= 1'b1;
      case (st)
        ST_RX:    if (setup_done) st <= setup_needs_reply ? ST_REPLY : ST_IDLE;
        ST_REPLY: if (resp_loaded) st <= ST_TX;
        ST_TX:    if (fifo_empty || (usb_pop_ok && cnt == CW'(1))) st <= ST_IDLE;
        default:  st <= st;
      endcase
    end
  end

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R2
  setup_flush_chk: assert property (@(posedge clk) disable iff (rst)
    setup_start |=> (fill_count == '0) && (ep_state == 2'd1) && !overflow && !underflow);

  // R7
  idle_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ep_state == 2'd0 && reg_wr && !reg_rd && !setup_start) |=> fill_count == $past(fill_count));

  // R8
  full_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ep_state == 2'd2 && fifo_full && reg_wr && !reg_rd && !setup_start)
      |=> overflow && (fill_count == $past(fill_count)));

  // R5
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow && !setup_start) |=> underflow);

  // R10
  tx_empty_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (ep_state == 2'd3 && fifo_empty && !setup_start) |=> ep_state == 2'd0);

  // R12
  tx_read_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (ep_state == 2'd3 && reg_rd && !usb_pop && !setup_start)
      |=> (fill_count == $past(fill_count)) && (underflow == $past(underflow)));
endmodule

// File: tb/ctl_ep_fifo_tb_top.sv
`timescale 1ns/1ps
module ctl_ep_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_rd, reg_wr, resp_loaded, setup_start, setup_done, setup_needs_reply;
  logic        usb_push, usb_pop;
  logic [7:0]  reg_wdata, usb_wdata, usb_rdata;
  logic [31:0] reg_rdata;
  logic [1:0]  ep_state;
  logic [4:0]  fill_count;
  logic        fifo_empty, fifo_full, overflow, underflow;

  always #2 clk = ~clk;

  ctl_ep_fifo dut_i (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .resp_loaded(resp_loaded), .setup_start(setup_start),
    .setup_done(setup_done), .setup_needs_reply(setup_needs_reply), .usb_push(usb_push),
    .usb_wdata(usb_wdata), .usb_pop(usb_pop), .usb_rdata(usb_rdata), .ep_state(ep_state),
    .fill_count(fill_count), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .overflow(overflow), .underflow(underflow));

  int checks = 0, fails = 0;
  bit done = 0;
  int m_st;
  byte unsigned q[$];
  bit m_ovf, m_unf;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    reg_rd = 0; reg_wr = 0; reg_wdata = 0; resp_loaded = 0; setup_start = 0;
    setup_done = 0; setup_needs_reply = 0; usb_push = 0; usb_wdata = 0; usb_pop = 0;
  endtask

  task automatic check_regs();
    chk(ep_state == 2'(m_st), "R6 state", ep_state, m_st);
    chk(fill_count == 5'(q.size()), "R11 count", fill_count, q.size());
    chk(fifo_empty == (q.size() == 0), "R11 empty", fifo_empty, q.size() == 0);
    chk(fifo_full == (q.size() == 16), "R11 full", fifo_full, q.size() == 16);
    chk(overflow == m_ovf, "R8 overflow", overflow, m_ovf);
    chk(underflow == m_unf, "R5 underflow", underflow, m_unf);
  endtask

  // inputs already driven; compares, advances one clock, updates model, compares
  task automatic step();
    int sz;
    int exp_rd, exp_usb;
    sz = q.size();
    #1;
    exp_rd  = (reg_rd && m_st != 3 && sz > 0) ? int'(q[0]) : 0;
    exp_usb = (m_st == 3 && sz > 0) ? int'(q[0]) : 0;
    chk(reg_rdata == 32'(exp_rd), "R4 reg_rdata", reg_rdata, exp_rd);
    chk(usb_rdata == 8'(exp_usb), "R9 usb_rdata", usb_rdata, exp_usb);
    @(posedge clk);
    if (setup_start) begin
      q.delete(); m_st = 1; m_ovf = 0; m_unf = 0;
    end else begin
      int nst;
      nst = m_st;
      if (reg_rd && m_st != 3) begin
        if (sz == 0) m_unf = 1; else void'(q.pop_front());
      end
      if (usb_pop && m_st == 3 && sz > 0) void'(q.pop_front());
      if ((reg_wr && m_st == 2) || (usb_push && m_st == 1)) begin
        if (sz == 16) m_ovf = 1;
        else q.push_back(m_st == 2 ? reg_wdata : usb_wdata);
      end
      if (m_st == 1 && setup_done) nst = setup_needs_reply ? 2 : 0;
      if (m_st == 2 && resp_loaded) nst = 3;
      if (m_st == 3 && (sz == 0 || (usb_pop && sz == 1))) nst = 0;
      m_st = nst;
    end
    @(negedge clk);
    check_regs();
    idle_inputs();
  endtask

  task automatic do_setup();         setup_start = 1; step(); endtask
  task automatic do_push(byte unsigned b); usb_push = 1; usb_wdata = b; step(); endtask
  task automatic do_done(bit reply); setup_done = 1; setup_needs_reply = reply; step(); endtask
  task automatic do_read();          reg_rd = 1; step(); endtask
  task automatic do_write(byte unsigned b); reg_wr = 1; reg_wdata = b; step(); endtask
  task automatic do_upop();          usb_pop = 1; step(); endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c;
    idle_inputs();
    rst = 1;
    m_st = 0; m_ovf = 0; m_unf = 0; q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk(ep_state == 0 && fill_count == 0 && fifo_empty && !fifo_full && !overflow && !underflow,
        "R1 reset", {ep_state, fill_count}, 0);
    check_regs();

    // R7 write while idle ignored
    do_write(8'hAA);
    chk(fill_count == 0, "R7 idle write", fill_count, 0);
    // R3 push while idle ignored
    do_push(8'h55);
    chk(fill_count == 0, "R3 idle push", fill_count, 0);

    // command with no reply; R4 read order; R5 underflow
    do_setup();
    for (int i = 0; i < 5; i++) do_push(8'(8'h10 + i));
    do_write(8'hEE);
    chk(fill_count == 5, "R7 rx write", fill_count, 5);
    do_done(0);
    chk(ep_state == 0, "R6 no reply", ep_state, 0);
    for (int i = 0; i < 5; i++) do_read();
    do_read();
    chk(underflow == 1, "R5 sticky", underflow, 1);
    do_push(8'h01);
    chk(underflow == 1 && fill_count == 0, "R5 held / R3 idle", underflow, 1);

    // command with reply; fill reply to overflow; R8 read+write on full
    do_setup();
    chk(underflow == 0, "R2 flags cleared", underflow, 0);
    for (int i = 0; i < 8; i++) do_push(8'(8'h20 + i));
    do_done(1);
    chk(ep_state == 2, "R6 reply", ep_state, 2);
    for (int i = 0; i < 8; i++) do_read();
    reg_rd = 1; reg_wr = 1; reg_wdata = 8'h77; step();   // empty: underflow yet write lands
    chk(fill_count == 1 && underflow, "R5 empty rd+wr", fill_count, 1);
    for (int i = 1; i < 16; i++) do_write(8'(8'h80 + i));
    chk(fifo_full == 1, "R11 full", fifo_full, 1);
    reg_rd = 1; reg_wr = 1; reg_wdata = 8'hCC; step();   // full: write dropped
    chk(overflow == 1 && fill_count == 15, "R8 full rd+wr", fill_count, 15);
    do_write(8'h99);
    resp_loaded = 1; step();
    chk(ep_state == 3, "R9 to tx", ep_state, 3);
    do_read();
    chk(fill_count == 16, "R12 tx read", fill_count, 16);
    do_write(8'h44);
    chk(fill_count == 16, "R7 tx write", fill_count, 16);
    for (int i = 0; i < 16; i++) do_upop();
    chk(ep_state == 0, "R10 last pop", ep_state, 0);

    // R3 overflow from packet side
    do_setup();
    for (int i = 0; i < 17; i++) do_push(8'(i));
    chk(overflow == 1 && fill_count == 16, "R8 usb push full", fill_count, 16);

    // R2 setup mid-transmit flushes stale data
    do_done(1);
    for (int i = 0; i < 16; i++) do_read();
    do_write(8'h3C); do_write(8'h3D);
    resp_loaded = 1; step();
    do_upop();
    do_setup();
    chk(fill_count == 0 && ep_state == 1, "R2 mid tx", fill_count, 0);

    // R10 zero-length reply
    do_done(1);
    resp_loaded = 1; step();
    step();
    chk(ep_state == 0, "R10 zero length", ep_state, 0);

    // random traffic against the queue model (R4 R9 R11 wrap)
    c = 0;
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      setup_start = (r < 2);
      setup_done  = ($urandom_range(0, 9) == 0);
      setup_needs_reply = $urandom_range(0, 3) != 0;
      resp_loaded = ($urandom_range(0, 11) == 0);
      usb_push = $urandom_range(0, 1); usb_wdata = 8'($urandom);
      usb_pop  = $urandom_range(0, 1);
      reg_rd   = ($urandom_range(0, 2) == 0);
      reg_wr   = $urandom_range(0, 1); reg_wdata = 8'($urandom);
      step();
      c++;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule